// File: doc/BRIEF.md
# Add-On Register and FIFO Access Port

This block is the slave port on the local side of a bus bridge. An add-on processor on that side uses it to read and write a small set of 32-bit registers and a status word. It also moves data through two FIFOs: outbound words go from the add-on side toward the host, and inbound words come from the host toward the add-on side. Accesses are framed by an active-low select together with an active-low read or write strobe. A 5-bit word address picks the target and active-low byte enables qualify the lanes. A mode pin chooses between a 32-bit and a 16-bit data path.

For DMA-style streaming, two direct active-low FIFO strobes reach the FIFO port without the select or any address decode. The outbound-full and inbound-empty pins are active low when a transfer can proceed, so each can drive a DMA request line directly. The host side of the bridge sees the other end of each FIFO through a plain synchronous push or pop interface. All add-on strobes are asynchronous. The port synchronizes them and acts once per strobe assertion.

Top module: `addon_port`

## Requirements
- R1: After reset every register and the status word read as zero, both FIFOs are empty, `wr_full` is 0, `rd_empty` is 1, `a2h_avail` is 0, and `dq_out` is 0 while no read strobe is active.
- R2: A register write takes place only when `sel_n` and `wr_n` are both low. `wr_n` low with `sel_n` high changes nothing, and `rd_n` low with `sel_n` high leaves `dq_out` at 0.
- R3: In 32-bit mode (`mode16`=0) a register write updates byte lane k (bits 8k+7:8k) only when `be_n[k]` is 0.
- R4: With `mode16`=1 the data path is `dq_in[15:0]`/`dq_out[15:0]`, `dq_out[31:16]` reads 0, and `be_n[3]` acts as address bit 1: 0 selects bits 15:0 and 1 selects bits 31:16 of the word. `be_n[0]` and `be_n[1]` enable the low and high byte of that halfword.
- R5: Word address 8 (5'b01000) is the FIFO port. A write there pushes the whole word into the outbound FIFO, whatever the byte enables. A read returns the head of the inbound FIFO, or 0 if it is empty, and pops it when the read ends. Both FIFOs keep first-in, first-out order.
- R6: `fifo_wr_n` low pushes and `fifo_rd_n` low reads and pops the FIFO port exactly as address 8 does. `sel_n`, `wr_n`, `rd_n` and `adr` are ignored, and the width still follows `mode16`.
- R7: `wr_full` is 1 exactly when the outbound FIFO holds 8 entries. `rd_empty` is 0 exactly when the inbound FIFO holds at least one entry.
- R8: In 16-bit mode a FIFO write with address bit 1 = 0 only stores the low halfword. The write with address bit 1 = 1 pushes {upper, stored lower}. A FIFO read of the low half does not pop. The read of the upper half pops.
- R9: A push into a full outbound FIFO is dropped and sets status bit 0. A pop from an empty inbound FIFO is ignored and sets status bit 1. Both bits stay set until a write to word address 9 with lane 0 enabled carries a 1 in that bit position.
- R10: Holding a write strobe for any number of cycles performs exactly one write. A read pops at most once per strobe assertion, after the strobe is released.
- R11: Word address 9 reads the status word: bit 0 overflow, bit 1 underflow, bits 11:8 outbound count, bits 19:16 inbound count. Word addresses 0 to 3 are the general registers. All other addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low port select |
| wr_n | input | 1 | Active-low register write strobe |
| rd_n | input | 1 | Active-low register read strobe |
| adr | input | 5 | Word address (byte address bits 6:2) |
| be_n | input | 4 | Active-low byte enables; bit 3 is address bit 1 in 16-bit mode |
| mode16 | input | 1 | 0 = 32-bit data path, 1 = 16-bit data path |
| dq_in | input | 32 | Write data from the add-on bus |
| dq_out | output | 32 | Read data toward the add-on bus, 0 when not reading |
| fifo_wr_n | input | 1 | Active-low direct FIFO write strobe |
| fifo_rd_n | input | 1 | Active-low direct FIFO read strobe |
| wr_full | output | 1 | Outbound FIFO full; low requests a DMA write |
| rd_empty | output | 1 | Inbound FIFO empty; low requests a DMA read |
| h2a_push | input | 1 | Host side push into the inbound FIFO |
| h2a_wdata | input | 32 | Host side data for the inbound FIFO |
| a2h_pop | input | 1 | Host side pop from the outbound FIFO |
| a2h_rdata | output | 32 | Head of the outbound FIFO, 0 when empty |
| a2h_avail | output | 1 | Outbound FIFO holds data |

## Verification
The bench builds the port with its defaults: FIFO depth 8, four general registers and two synchronizer stages. With a depth of 8, a full outbound FIFO and a dropped ninth push are reached in a handful of strobes. A 4-bit count field then shows the full value 8 in the status word. Two synchronizer stages fix the latency from strobe to effect at three clock edges, so one long strobe can be compared against the single write it must produce. Four registers leave addresses 4 to 7 and 10 upward unmapped to probe the read-as-zero rule.

// File: rtl/addon_pkg.sv
package addon_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int BYTES  = DATA_W / 8;
  localparam int HALF_W = DATA_W / 2;

  localparam logic [ADDR_W-1:0] FIFO_WADDR = 5'b01000;
  localparam logic [ADDR_W-1:0] STAT_WADDR = 5'b01001;

  localparam int STAT_OVF_BIT  = 0;
  localparam int STAT_UDF_BIT  = 1;
  localparam int STAT_A2H_LSB  = 8;
  localparam int STAT_H2A_LSB  = 16;

  typedef struct packed {
    logic udf;
    logic ovf;
  } sticky_t;
endpackage

// File: rtl/addon_strobe_sync.sv
module addon_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic level,
  output logic lead,
  output logic trail
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], strobe};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level = sync_q[SYNC_STAGES-1];
  assign lead  = level & ~prev_q;
  assign trail = ~level & prev_q;

  // one action per strobe assertion
  assert_single_lead_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lead |=> !lead);
  assert_single_trail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trail |=> !trail);
endmodule

// File: rtl/addon_fifo.sv
module addon_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    count_q, count_d;
  logic             do_push, do_pop;

  assign full    = (count_q == FULL_CNT);
  assign empty   = (count_q == '0);
  assign count   = count_q;
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = empty ? '0 : mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + AW'(1);
    if (do_pop)  rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + AW'(1);
    count_d = count_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata;
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (count_q == $past(count_q)));
  assert_empty_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/addon_regfile.sv
module addon_regfile #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int BYTES   = DATA_W / 8,
  localparam int IW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [BYTES-1:0]  lane_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] regs_d [NUM_REGS];
  logic [NUM_REGS-1:0] reg_we;

  assign rd_data = regs_q[rd_idx];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_comb begin
      reg_we[r] = wr_en && (wr_idx == IW'(r));
      regs_d[r] = regs_q[r];
      for (int b = 0; b < BYTES; b++) begin
        if (lane_en[b]) regs_d[r][8*b +: 8] = wr_data[8*b +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          regs_q[r] <= '0;
      else if (reg_we[r])  regs_q[r] <= regs_d[r];
    end

    assert_lane_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we[r] && !lane_en[0]) |=> (regs_q[r][7:0] == $past(regs_q[r][7:0])));
    assert_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_q[r]));
  end
endmodule

// File: rtl/addon_port.sv
module addon_port
  import addon_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int NUM_REGS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_n,
  input  logic        wr_n,
  input  logic        rd_n,
  input  logic [4:0]  adr,
  input  logic [3:0]  be_n,
  input  logic        mode16,
  input  logic [31:0] dq_in,
  output logic [31:0] dq_out,
  input  logic        fifo_wr_n,
  input  logic        fifo_rd_n,
  output logic        wr_full,
  output logic        rd_empty,
  input  logic        h2a_push,
  input  logic [31:0] h2a_wdata,
  input  logic        a2h_pop,
  output logic [31:0] a2h_rdata,
  output logic        a2h_avail
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [ADDR_W-1:0] REG_LIMIT = ADDR_W'(NUM_REGS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       irst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign irst_n = rst_sync_q[1];

  // raw strobe decode (active high)
  logic sel, reg_wr_raw, reg_rd_raw, dir_wr, dir_rd;
  logic fifo_wsel, fifo_rsel, reg_hit, stat_hit, half;
  assign sel        = ~sel_n;
  assign reg_wr_raw = sel & ~wr_n;
  assign reg_rd_raw = sel & ~rd_n;
  assign dir_wr     = ~fifo_wr_n;
  assign dir_rd     = ~fifo_rd_n;
  assign half       = mode16 & be_n[3];
  assign reg_hit    = (adr < REG_LIMIT);
  assign stat_hit   = (adr == STAT_WADDR);
  assign fifo_wsel  = dir_wr | (reg_wr_raw & (adr == FIFO_WADDR));
  assign fifo_rsel  = dir_rd | (reg_rd_raw & (adr == FIFO_WADDR));

  logic wr_level, wr_lead, wr_trail, rd_level, rd_lead, rd_trail;

  addon_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(irst_n), .strobe(reg_wr_raw | dir_wr),
    .level(wr_level), .lead(wr_lead), .trail(wr_trail));

  addon_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(irst_n), .strobe(reg_rd_raw | dir_rd),
    .level(rd_level), .lead(rd_lead), .trail(rd_trail));

  // lane enables and lane data for both widths
  logic [BYTES-1:0]  lane_en;
  logic [DATA_W-1:0] lane_data;
  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      if (mode16) lane_en[b] = ((b / 2) == int'(half)) && !be_n[b % 2];
      else        lane_en[b] = !be_n[b];
    end
    lane_data = mode16 ? {dq_in[HALF_W-1:0], dq_in[HALF_W-1:0]} : dq_in;
  end

  // write side next state
  logic              hold_en, push_a2h, reg_we;
  logic [HALF_W-1:0] hold_q;
  logic [DATA_W-1:0] push_data;
  logic [1:0]        clr_bits;
  always_comb begin
    hold_en   = 1'b0;
    push_a2h  = 1'b0;
    reg_we    = 1'b0;
    clr_bits  = 2'b00;
    push_data = mode16 ? {dq_in[HALF_W-1:0], hold_q} : dq_in;
    if (wr_lead) begin
      if (fifo_wsel) begin
        if (mode16 && !half) hold_en  = 1'b1;
        else                 push_a2h = 1'b1;
      end else if (reg_wr_raw && reg_hit) begin
        reg_we = 1'b1;
      end else if (reg_wr_raw && stat_hit && lane_en[0]) begin
        clr_bits = lane_data[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n)      hold_q <= '0;
    else if (hold_en) hold_q <= dq_in[HALF_W-1:0];
  end

  // read side: pop decided at the leading edge, performed at release
  logic pop_pend_q, pop_pend_d, pop_h2a;
  always_comb begin
    pop_pend_d = pop_pend_q;
    if (rd_lead)       pop_pend_d = fifo_rsel & (~mode16 | half);
    else if (rd_trail) pop_pend_d = 1'b0;
  end
  assign pop_h2a = rd_trail & pop_pend_q;

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) pop_pend_q <= 1'b0;
    else         pop_pend_q <= pop_pend_d;
  end

  // FIFOs
  logic [DATA_W-1:0] h2a_head;
  logic              a2h_full, a2h_empty, h2a_full, h2a_empty;
  logic [CW-1:0]     a2h_cnt, h2a_cnt;

  addon_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_a2h (
    .clk(clk), .rst_n(irst_n), .push(push_a2h), .wdata(push_data),
    .pop(a2h_pop), .rdata(a2h_rdata), .full(a2h_full), .empty(a2h_empty),
    .count(a2h_cnt));

  addon_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_h2a (
    .clk(clk), .rst_n(irst_n), .push(h2a_push), .wdata(h2a_wdata),
    .pop(pop_h2a), .rdata(h2a_head), .full(h2a_full), .empty(h2a_empty),
    .count(h2a_cnt));

  // sticky errors: a set wins over a clear in the same cycle
  sticky_t sticky_q, sticky_d;
  always_comb begin
    sticky_d.ovf = (sticky_q.ovf & ~clr_bits[STAT_OVF_BIT]) | (push_a2h & a2h_full);
    sticky_d.udf = (sticky_q.udf & ~clr_bits[STAT_UDF_BIT]) | (pop_h2a & h2a_empty);
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) sticky_q <= '0;
    else         sticky_q <= sticky_d;
  end

  // register file
  logic [DATA_W-1:0] reg_rdata;
  addon_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(irst_n), .wr_en(reg_we), .wr_idx(adr[IW-1:0]),
    .lane_en(lane_en), .wr_data(lane_data), .rd_idx(adr[IW-1:0]),
    .rd_data(reg_rdata));

  // read mux, combinational while a read strobe is held
  logic [DATA_W-1:0] status_word, rd_word;
  always_comb begin
    status_word = '0;
    status_word[STAT_OVF_BIT] = sticky_q.ovf;
    status_word[STAT_UDF_BIT] = sticky_q.udf;
    status_word[STAT_A2H_LSB +: CW] = a2h_cnt;
    status_word[STAT_H2A_LSB +: CW] = h2a_cnt;

    if (fifo_rsel)                 rd_word = h2a_head;
    else if (reg_rd_raw && reg_hit)  rd_word = reg_rdata;
    else if (reg_rd_raw && stat_hit) rd_word = status_word;
    else                             rd_word = '0;

    if (mode16) dq_out = {{HALF_W{1'b0}}, half ? rd_word[DATA_W-1:HALF_W] : rd_word[HALF_W-1:0]};
    else        dq_out = rd_word;
  end

  assign wr_full   = a2h_full;
  assign rd_empty  = h2a_empty;
  assign a2h_avail = ~a2h_empty;

  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!irst_n)
    (wr_full && !a2h_pop) |=> wr_full);
  assert_empty_hold_R7: assert property (@(posedge clk) disable iff (!irst_n)
    (rd_empty && !h2a_push) |=> rd_empty);
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!irst_n)
    mode16 |-> (dq_out[31:16] == '0));
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!irst_n)
    (sticky_q.ovf && !wr_lead) |=> sticky_q.ovf);
  assert_pop_once_R10: assert property (@(posedge clk) disable iff (!irst_n)
    pop_h2a |=> !pop_h2a);

  logic unused_ok;
  assign unused_ok = ^{wr_level, wr_trail, rd_level, h2a_full, be_n[2]};
endmodule

// File: tb/tb_addon_port.sv
module tb_addon_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_n, wr_n, rd_n, mode16, fifo_wr_n, fifo_rd_n;
  logic [4:0]  adr;
  logic [3:0]  be_n;
  logic [31:0] dq_in, dq_out, h2a_wdata, a2h_rdata;
  logic        wr_full, rd_empty, h2a_push, a2h_pop, a2h_avail;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  addon_port dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
    .adr(adr), .be_n(be_n), .mode16(mode16), .dq_in(dq_in), .dq_out(dq_out),
    .fifo_wr_n(fifo_wr_n), .fifo_rd_n(fifo_rd_n), .wr_full(wr_full),
    .rd_empty(rd_empty), .h2a_push(h2a_push), .h2a_wdata(h2a_wdata),
    .a2h_pop(a2h_pop), .a2h_rdata(a2h_rdata), .a2h_avail(a2h_avail));

  // {adr, be_n, write data, expected read-back}, 32-bit mode
  localparam logic [72:0] VEC [8] = '{
    {5'd0, 4'b0000, 32'h11223344, 32'h11223344},
    {5'd1, 4'b0000, 32'hA5A5A5A5, 32'hA5A5A5A5},
    {5'd0, 4'b1110, 32'hFFFFFFEE, 32'h112233EE},
    {5'd0, 4'b0111, 32'h99000000, 32'h992233EE},
    {5'd2, 4'b1010, 32'h12345678, 32'h00340078},
    {5'd3, 4'b1111, 32'hDEADBEEF, 32'h00000000},
    {5'd5, 4'b0000, 32'hCAFEF00D, 32'h00000000},
    {5'd1, 4'b1001, 32'h00BBCC00, 32'hA5BBCCA5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit direct, input logic [4:0] a,
                        input logic [3:0] be, input logic [31:0] d, input bit m16,
                        input int hold, output logic [31:0] rdv);
    @(negedge clk);
    mode16 = m16; adr = a; be_n = be; dq_in = d;
    if (direct) begin
      if (wr) fifo_wr_n = 1'b0; else fifo_rd_n = 1'b0;
    end else begin
      sel_n = 1'b0;
      if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    end
    repeat (2) @(negedge clk);
    rdv = dq_out;
    repeat (hold - 2) @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; fifo_wr_n = 1'b1; fifo_rd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_push(input logic [31:0] d);
    @(negedge clk); h2a_push = 1'b1; h2a_wdata = d;
    @(negedge clk); h2a_push = 1'b0;
  endtask

  task automatic host_pop();
    @(negedge clk); a2h_pop = 1'b1;
    @(negedge clk); a2h_pop = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %h expected %h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; mode16 = 1'b0;
    fifo_wr_n = 1'b1; fifo_rd_n = 1'b1; adr = '0; be_n = '1; dq_in = '0;
    h2a_push = 1'b0; h2a_wdata = '0; a2h_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 wr_full", {31'd0, wr_full}, 32'd0);
    check("R1 rd_empty", {31'd0, rd_empty}, 32'd1);
    check("R1 a2h_avail", {31'd0, a2h_avail}, 32'd0);
    check("R1 dq_out idle", dq_out, 32'd0);
    access(1'b0, 1'b0, 5'd0, 4'b0000, 32'd0, 1'b0, 4, r);
    check("R1 reg0 reset", r, 32'd0);
    access(1'b0, 1'b0, 5'd9, 4'b0000, 32'd0, 1'b0, 4, r);
    check("R1 status reset", r, 32'd0);

    // R3 lanes and R11 unmapped, table driven
    for (int i = 0; i < 8; i++) begin
      access(1'b1, 1'b0, VEC[i][72:68], VEC[i][67:64], VEC[i][63:32], 1'b0, 4, r);
      access(1'b0, 1'b0, VEC[i][72:68], 4'b0000, 32'd0, 1'b0, 4, r);
      check($sformatf("R3/R11 vector %0d", i), r, VEC[i][31:0]);
    end

    // R2 strobes without select
    @(negedge clk); adr = 5'd0; be_n = 4'b0000; dq_in = 32'h0; wr_n = 1'b0;
    repeat (6) @(negedge clk); wr_n = 1'b1; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 read without select", dq_out, 32'd0);
    rd_n = 1'b1; repeat (4) @(negedge clk);
    access(1'b0, 1'b0, 5'd0, 4'b0000, 32'd0, 1'b0, 4, r);
    check("R2 reg0 unchanged", r, 32'h992233EE);

    // R10 long strobe writes once; R5 FIFO order
    access(1'b1, 1'b0, 5'd8, 4'b1111, 32'h10000001, 1'b0, 12, r);
    access(1'b1, 1'b0, 5'd8, 4'b0000, 32'h10000002, 1'b0, 4, r);
    check("R5 a2h head 1", a2h_rdata, 32'h10000001);
    host_pop();
    check("R10 single push, head 2", a2h_rdata, 32'h10000002);
    host_pop();
    check("R10 a2h drained", {31'd0, a2h_avail}, 32'd0);

    // R6 direct write ignores select and address
    access(1'b1, 1'b1, 5'd0, 4'b0000, 32'h20000003, 1'b0, 4, r);
    check("R6 direct push", a2h_rdata, 32'h20000003);
    access(1'b0, 1'b0, 5'd0, 4'b0000, 32'd0, 1'b0, 4, r);
    check("R6 reg0 untouched", r, 32'h992233EE);
    host_pop();

    // R7 full, R9 overflow
    for (int k = 0; k < 8; k++)
      access(1'b1, 1'b1, 5'd0, 4'b0000, 32'h30000000 + k, 1'b0, 4, r);
    check("R7 wr_full at 8", {31'd0, wr_full}, 32'd1);
    access(1'b1, 1'b1, 5'd0, 4'b0000, 32'h3FFFFFFF, 1'b0, 4, r);
    access(1'b0, 1'b0, 5'd9, 4'b0000, 32'd0, 1'b0, 4, r);
    check("R9/R11 status overflow", r, 32'h00000801);
    for (int k = 0; k < 8; k++) begin
      check($sformatf("R9 a2h entry %0d", k), a2h_rdata, 32'h30000000 + k);
      host_pop();
      if (k == 0) check("R7 wr_full released", {31'd0, wr_full}, 32'd0);
    end
    check("R9 ninth dropped", {31'd0, a2h_avail}, 32'd0);
    access(1'b0, 1'b0, 5'd9, 4'b0000, 32'd0, 1'b0, 4, r);
    check("R9 sticky kept", r, 32'h00000001);
    access(1'b1, 1'b0, 5'd9, 4'b0000, 32'h00000001, 1'b0, 4, r);
    access(1'b0, 1'b0, 5'd9, 4'b0000, 32'd0, 1'b0, 4, r);
    check("R9 cleared", r, 32'd0);

    // R5 inbound FIFO, R7 empty flag, R10 single pop
    host_push(32'h40000001);
    host_push(32'h40000002);
    @(negedge clk);
    check("R7 rd_empty low", {31'd0, rd_empty}, 32'd0);
    access(1'b0, 1'b0, 5'd8, 4'b0000, 32'd0, 1'b0, 10, r);
    check("R5 h2a first", r, 32'h40000001);
    access(1'b0, 1'b1, 5'd3, 4'b0000, 32'd0, 1'b0, 4, r);
    check("R6 direct read second", r, 32'h40000002);
    check("R7 rd_empty high", {31'd0, rd_empty}, 32'd1);

    // R9 underflow
    access(1'b0, 1'b0, 5'd8, 4'b0000, 32'd0, 1'b0, 4, r);
    check("R9 empty read zero", r, 32'd0);
    access(1'b0, 1'b0, 5'd9, 4'b0000, 32'd0, 1'b0, 4, r);
    check("R9 status underflow", r, 32'h00000002);
    access(1'b1, 1'b0, 5'd9, 4'b0000, 32'h00000002, 1'b0, 4, r);

    // R4 16-bit register access
    access(1'b1, 1'b0, 5'd2, 4'b1000, 32'h0000BEEF, 1'b1, 4, r);
    access(1'b0, 1'b0, 5'd2, 4'b0000, 32'd0, 1'b0, 4, r);
    check("R4 upper half write", r, 32'hBEEF0078);
    access(1'b0, 1'b0, 5'd2, 4'b1000, 32'd0, 1'b1, 4, r);
    check("R4 read upper half", r, 32'h0000BEEF);
    access(1'b0, 1'b0, 5'd2, 4'b0000, 32'd0, 1'b1, 4, r);
    check("R4 read lower half", r, 32'h00000078);
    access(1'b1, 1'b0, 5'd2, 4'b0010, 32'h000055AA, 1'b1, 4, r);
    access(1'b0, 1'b0, 5'd2, 4'b0000, 32'd0, 1'b0, 4, r);
    check("R4 low byte only", r, 32'hBEEF00AA);

    // R8 16-bit FIFO assembly
    access(1'b1, 1'b0, 5'd8, 4'b0000, 32'h00001111, 1'b1, 4, r);
    check("R8 lower alone no push", {31'd0, a2h_avail}, 32'd0);
    access(1'b1, 1'b1, 5'd0, 4'b1000, 32'h00002222, 1'b1, 4, r);
    check("R8 assembled word", a2h_rdata, 32'h22221111);
    host_pop();
    host_push(32'hCAFE1234);
    access(1'b0, 1'b1, 5'd0, 4'b0000, 32'd0, 1'b1, 4, r);
    check("R8 read lower", r, 32'h00001234);
    check("R8 lower no pop", {31'd0, rd_empty}, 32'd0);
    access(1'b0, 1'b0, 5'd8, 4'b1000, 32'd0, 1'b1, 4, r);
    check("R8 read upper", r, 32'h0000CAFE);
    check("R8 upper pops", {31'd0, rd_empty}, 32'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule